// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block holds a vector of interrupt causes, one bit per source, beside the per-bit controls that decide how each cause is masked and how it is cleared. Hardware events arrive as one-cycle pulses on an event vector and are latched into the cause register. Software reaches the bank through a simple register port with a read strobe, a write strobe and an address. Through this port it can raise causes itself, set or clear mask bits without a read-modify-write, and choose for every bit whether reading the cause register clears it or a write of one clears it.

A single summary output reports whether any latched cause is currently unmasked. It is meant to feed a higher-level aggregator. Masking never stops a cause from being latched. It only keeps that cause out of the summary output, so software can still poll for masked causes.

Register map (address on `reg_addr`): 0 = cause (read, and write-one-to-clear), 1 = cause set, 2 = mask set, 3 = mask clear, 4 = clear mode (read/write), 5 = mask value (read only). Addresses 1, 2, 3, 6 and 7 read back as zero.

Top module: `irq_cause_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the cause register is all zeros, the mask is all ones, the clear-mode register is all zeros, `reg_rdata` is zero and `irq_pending` is low.
- R2: A one on bit i of `evt_in` at a rising edge sets cause bit i, whether or not mask bit i is set. A read of address 0 returns the cause vector.
- R3: Writing to address 2 sets every mask bit whose data bit is one. Zero data bits leave those mask bits unchanged.
- R4: Writing to address 3 clears every mask bit whose data bit is one. Zero data bits leave those mask bits unchanged.
- R5: Reading address 5 returns the current mask and changes no state.
- R6: A read of address 0 clears, after returning it, every cause bit whose clear-mode bit is 1. Cause bits whose clear-mode bit is 0 are not cleared by reads.
- R7: Writing to address 0 clears cause bits that have clear-mode 0 and a data bit of one. It leaves alone bits in clear-mode 1 and bits whose data bit is zero.
- R8: Writing to address 1 sets every cause bit whose data bit is one.
- R9: If an event pulse and a clear by write or by read hit the same cause bit at the same edge, the bit stays set.
- R10: `irq_pending` is high exactly when some cause bit is set while its mask bit is clear, as seen after the most recent edge.
- R11: Read data is registered. It appears on `reg_rdata` in the cycle after `reg_rd_en` and holds until the next read. Reads of unmapped or write-only addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NBITS | Hardware event pulses, one per cause bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NBITS | Register write data |
| reg_rdata | output | NBITS | Registered read data |
| irq_pending | output | 1 | Any unmasked cause is set |

## Verification
An event pulse and a clear can land on the same cause bit at the same edge. The clear can come from a write of one to a write-clear bit or from a read of a read-clear bit. The bench drives the event vector in the same cycle as the clearing access. It then reads the cause register back, expecting the colliding bit to remain set while the other bits follow their clear rules. A behavioural reference model, updated on every edge and compared every cycle, judges read data and the summary output through these collisions and every other access.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int BANK_ADDR_W = 3;

    typedef enum logic [BANK_ADDR_W-1:0] {
        REG_CAUSE     = 3'd0,
        REG_CAUSE_SET = 3'd1,
        REG_MASK_SET  = 3'd2,
        REG_MASK_CLR  = 3'd3,
        REG_CLR_MODE  = 3'd4,
        REG_MASK_VAL  = 3'd5
    } bank_reg_e;

    typedef struct packed {
        logic cause_wr;
        logic cause_rd;
        logic set_wr;
        logic mset_wr;
        logic mclr_wr;
        logic mode_wr;
        logic mode_rd;
        logic mval_rd;
    } bank_strobe_t;

    function automatic bank_strobe_t decode_access(
        input logic                   wr,
        input logic                   rd,
        input logic [BANK_ADDR_W-1:0] addr
    );
        bank_strobe_t s;
        s = '0;
        unique case (addr)
            REG_CAUSE: begin
                s.cause_wr = wr;
                s.cause_rd = rd;
            end
            REG_CAUSE_SET: s.set_wr = wr;
            REG_MASK_SET:  s.mset_wr = wr;
            REG_MASK_CLR:  s.mclr_wr = wr;
            REG_CLR_MODE: begin
                s.mode_wr = wr;
                s.mode_rd = rd;
            end
            REG_MASK_VAL:  s.mval_rd = rd;
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic sw_set,
    input  logic w1c_hit,
    input  logic rd_hit,
    input  logic cor_mode,
    output logic q
);
    logic clr;

    always_comb begin
        clr = (w1c_hit & ~cor_mode) | (rd_hit & cor_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (q & ~clr) | evt | sw_set;
    end

    // R9: an event pulse always leaves the bit set
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        evt |=> q);

    // R6: read in clear-on-read mode clears the bit when nothing sets it
    p_cor_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && cor_mode && !evt && !sw_set) |=> !q);

    // R7: a write-one-clear is ignored for a clear-on-read bit
    p_w1c_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (w1c_hit && cor_mode && !rd_hit && q) |=> q);

    // R8: software set raises the bit
    p_sw_set_r8: assert property (@(posedge clk) disable iff (rst)
        sw_set |=> q);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [NBITS-1:0] wdata,
    output logic [NBITS-1:0] mask
);
    localparam logic [NBITS-1:0] ALL_MASKED = {NBITS{1'b1}};

    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] clr_vec;

    always_comb begin
        set_vec = set_wr ? wdata : '0;
        clr_vec = clr_wr ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask <= ALL_MASKED;
        else     mask <= (mask | set_vec) & ~clr_vec;
    end

    // R3: written ones end up set in the mask
    p_mask_set_r3: assert property (@(posedge clk) disable iff (rst)
        (set_wr && !clr_wr) |=> ((mask & $past(wdata)) == $past(wdata)));

    // R4: written ones end up cleared in the mask
    p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_wr) |=> ((mask & $past(wdata)) == '0));

    // R3/R4: zero data bits leave the mask alone
    p_mask_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (set_wr || clr_wr) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));

    // R5: with no mask write the mask holds
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_wr && !clr_wr) |=> $stable(mask));

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_bank_pkg::*;
#(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_strobe_t     stb,
    input  logic             rd_en,
    input  logic [NBITS-1:0] cause,
    input  logic [NBITS-1:0] mask,
    input  logic [NBITS-1:0] mode,
    output logic [NBITS-1:0] rdata
);
    logic [NBITS-1:0] rd_sel;

    always_comb begin
        rd_sel = '0;
        if (stb.cause_rd) rd_sel = cause;
        if (stb.mode_rd)  rd_sel = mode;
        if (stb.mval_rd)  rd_sel = mask;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_sel;
    end

    // R11: read data only moves on a read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R1: reset leaves the read data at zero
    p_rdata_reset_r1: assert property (@(posedge clk)
        rst |=> (rdata == '0));

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int NBITS = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NBITS-1:0]       evt_in,
    input  logic                   reg_wr_en,
    input  logic                   reg_rd_en,
    input  logic [BANK_ADDR_W-1:0] reg_addr,
    input  logic [NBITS-1:0]       reg_wdata,
    output logic [NBITS-1:0]       reg_rdata,
    output logic                   irq_pending
);
    bank_strobe_t     stb;
    logic [NBITS-1:0] cause_q;
    logic [NBITS-1:0] mask_q;
    logic [NBITS-1:0] mode_q;
    logic [NBITS-1:0] w1c_vec;
    logic [NBITS-1:0] set_vec;

    always_comb begin
        stb     = decode_access(reg_wr_en, reg_rd_en, reg_addr);
        w1c_vec = stb.cause_wr ? reg_wdata : '0;
        set_vec = stb.set_wr   ? reg_wdata : '0;
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_cause
        irq_cause_bit u_bit (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_in[i]),
            .sw_set   (set_vec[i]),
            .w1c_hit  (w1c_vec[i]),
            .rd_hit   (stb.cause_rd),
            .cor_mode (mode_q[i]),
            .q        (cause_q[i])
        );
    end

    irq_mask_reg #(.NBITS(NBITS)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_wr (stb.mset_wr),
        .clr_wr (stb.mclr_wr),
        .wdata  (reg_wdata),
        .mask   (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst)              mode_q <= '0;
        else if (stb.mode_wr) mode_q <= reg_wdata;
    end

    irq_read_port #(.NBITS(NBITS)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .stb   (stb),
        .rd_en (reg_rd_en),
        .cause (cause_q),
        .mask  (mask_q),
        .mode  (mode_q),
        .rdata (reg_rdata)
    );

    always_comb begin
        irq_pending = |(cause_q & ~mask_q);
    end

    // R1: state after reset
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cause_q == '0 && (&mask_q) && mode_q == '0));

    // R10: a fully masked bank never signals
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq_pending);

    // R10: an unmasked event is signalled on the next cycle
    p_unmasked_event_r10: assert property (@(posedge clk) disable iff (rst)
        ((evt_in & ~mask_q) != '0 && !stb.mset_wr) |=> irq_pending);

endmodule

// File: tb/test_irq_cause_bank.sv
module test_irq_cause_bank;
    localparam int NB = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] evt_in = '0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [NB-1:0] reg_wdata = '0;
    logic [NB-1:0] reg_rdata;
    logic          irq_pending;

    int n_checks = 0;
    int n_fail   = 0;
    string phase_tag = "R1";

    // reference model state
    logic [NB-1:0] m_cause, m_mask, m_mode, m_rdata;

    always #2.5 clk = ~clk;

    irq_cause_bank #(.NBITS(NB)) i_irq_cause_bank (
        .clk(clk), .rst(rst), .evt_in(evt_in),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pending(irq_pending)
    );

    task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [NB-1:0] clr;
        if (rst) begin
            m_cause = '0; m_mask = '1; m_mode = '0; m_rdata = '0;
        end else begin
            clr = '0;
            if (reg_wr_en && reg_addr == 3'd0) clr = clr | (reg_wdata & ~m_mode);
            if (reg_rd_en && reg_addr == 3'd0) clr = clr | m_mode;
            if (reg_rd_en) begin
                case (reg_addr)
                    3'd0: m_rdata = m_cause;
                    3'd4: m_rdata = m_mode;
                    3'd5: m_rdata = m_mask;
                    default: m_rdata = '0;
                endcase
            end
            m_cause = (m_cause & ~clr) | evt_in;
            if (reg_wr_en) begin
                case (reg_addr)
                    3'd1: m_cause = m_cause | reg_wdata;
                    3'd2: m_mask  = m_mask | reg_wdata;
                    3'd3: m_mask  = m_mask & ~reg_wdata;
                    3'd4: m_mode  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        check({phase_tag, " R11 rdata model"}, reg_rdata, m_rdata);
        check("R10 pending model", {31'd0, irq_pending}, {31'd0, |(m_cause & ~m_mask)});
    end

    task automatic drive(input logic [NB-1:0] e, input logic wr, input logic rd,
                         input logic [2:0] a, input logic [NB-1:0] d);
        @(posedge clk); #1;
        evt_in = e; reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle();
        drive('0, 1'b0, 1'b0, 3'd0, '0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NB-1:0] d);
        drive('0, 1'b1, 1'b0, a, d);
        idle();
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [NB-1:0] exp, input string tag);
        drive('0, 1'b0, 1'b1, a, '0);
        idle();
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic pend_chk(input logic exp, input string tag);
        #1 check(tag, {31'd0, irq_pending}, {31'd0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 rdata in reset", reg_rdata, '0);
        pend_chk(1'b0, "R1 pending in reset");
        rst = 1'b0;
        phase_tag = "R1";
        rd_chk(3'd5, 32'hFFFF_FFFF, "R1 mask after reset");
        rd_chk(3'd4, 32'h0, "R1 clear mode after reset");
        rd_chk(3'd0, 32'h0, "R1 cause after reset");

        phase_tag = "R2";
        drive(32'h0000_0021, 1'b0, 1'b0, 3'd0, '0);
        idle();
        pend_chk(1'b0, "R2 masked causes not pending");
        rd_chk(3'd0, 32'h0000_0021, "R2 masked events latched");
        rd_chk(3'd0, 32'h0000_0021, "R6 mode0 bits survive read");

        phase_tag = "R4";
        wr(3'd3, 32'h0000_0001);
        rd_chk(3'd5, 32'hFFFF_FFFE, "R4 mask clear");
        rd_chk(3'd5, 32'hFFFF_FFFE, "R5 mask read no side effect");
        pend_chk(1'b1, "R10 unmasked cause pending");

        phase_tag = "R3";
        wr(3'd2, 32'h0000_0001);
        rd_chk(3'd5, 32'hFFFF_FFFF, "R3 mask set");
        wr(3'd2, 32'h0);
        rd_chk(3'd5, 32'hFFFF_FFFF, "R3 zero write keeps mask");
        pend_chk(1'b0, "R10 masked again");

        phase_tag = "R7";
        wr(3'd0, 32'h0000_0001);
        rd_chk(3'd0, 32'h0000_0020, "R7 write-one clears mode0 bit");
        wr(3'd0, 32'h0);
        rd_chk(3'd0, 32'h0000_0020, "R7 zero write no effect");
        wr(3'd4, 32'h0000_0020);
        wr(3'd0, 32'h0000_0020);
        rd_chk(3'd0, 32'h0000_0020, "R7 write-one ignored in read-clear mode");
        rd_chk(3'd0, 32'h0, "R6 read cleared read-clear bit");

        phase_tag = "R8";
        wr(3'd1, 32'h8000_0000);
        rd_chk(3'd0, 32'h8000_0000, "R8 software set");
        wr(3'd3, 32'h8000_0000);
        pend_chk(1'b1, "R10 software cause unmasked");
        wr(3'd0, 32'h8000_0000);
        pend_chk(1'b0, "R10 cleared cause not pending");

        phase_tag = "R9";
        drive(32'h0000_0002, 1'b1, 1'b0, 3'd0, 32'h0000_0002);
        idle();
        rd_chk(3'd0, 32'h0000_0002, "R9 event beats write clear");
        wr(3'd4, 32'h0000_0024);
        drive(32'h0000_0004, 1'b0, 1'b1, 3'd0, '0);
        idle();
        #1 check("R9 read during event returns old cause", reg_rdata, 32'h0000_0002);
        rd_chk(3'd0, 32'h0000_0006, "R9 event beats read clear");
        rd_chk(3'd0, 32'h0000_0002, "R6 read-clear bit gone, mode0 kept");

        phase_tag = "R11";
        rd_chk(3'd6, 32'h0, "R11 unmapped read zero");
        rd_chk(3'd0, 32'h0000_0002, "R11 cause read");
        repeat (3) idle();
        #1 check("R11 rdata holds", reg_rdata, 32'h0000_0002);
        rd_chk(3'd2, 32'h0, "R11 write-only read zero");

        repeat (2) idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule